// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block turns a single request into a complete two-wire bus transaction for a memory or register device. It sits on top of a bit-level bus engine, which executes one primitive at a time: a start condition, a stop condition, a byte write that returns the target's acknowledge, or a byte read that sends a chosen acknowledge level. The sequencer orders these primitives for three operations. A presence probe checks whether a device answers. A random read first sets the device's internal pointer and then reads a burst. A write sends a pointer followed by a data burst.

A request carries an operation code, a 7-bit device address, an internal address of 0 to `ADDR_BYTES` bytes, the internal address length and a byte count. Outgoing data is pulled from a valid/ready stream and incoming data is pushed out on another valid/ready stream. When the transaction ends, a one-cycle completion pulse reports an error flag and the number of data bytes the target refused. Devices whose upper address bits live in the device-address field are handled by folding those bits, selected by the `OVF_MASK` parameter, into the device address.

Top module: `i2cseq_ctrl`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A request presented while busy has no effect: no bus command follows it once the current transaction ends.
- R2: Operation code 0 (probe; code 3 behaves the same) issues START, then a byte write of {device, 0}, then STOP. `done_err` is 1 exactly when that byte was refused (NACK).
- R3: Operation code 1 (read) with a nonzero address length issues START, a write of {device, 0}, the address bytes most significant first, STOP, START, and then a write of {device, 1}.
- R4: A read with address length 0 skips the pointer phase. It issues START and then {device, 1} directly.
- R5: If the {device, 0} byte of a read or write is refused, the block issues STOP and then completes with `done_err` = 1.
- R6: If an address byte is refused, the block completes at once with `done_err` = 1 and issues no further bus command, not even STOP.
- R7: In the read phase, the acknowledge of {device, 1} is ignored. Each byte is read with `bus_nack` = 0 except the last, which has `bus_nack` = 1. STOP follows. The bytes leave on `rd_data` in order and are held stable while `rd_ready` is low.
- R8: Operation code 2 (write) issues START, {device, 0}, the address bytes, the data bytes in stream order, then STOP. A refused data byte increments `done_fails` and never aborts the transfer. `done_err` is 0 when the device and address bytes were accepted.
- R9: The device address used on the bus is the request's device address ORed with (internal address shifted right by 8 x address length) masked by `OVF_MASK`. With an address length equal to `ADDR_BYTES`, nothing is folded.
- R10: A write with byte count 0 runs the pointer phase and then STOP. A read with byte count 0 and nonzero address length runs only the pointer phase and then STOP.
- R11: Only one bus command is outstanding at a time (`bus_go` is a one-cycle pulse awaiting `bus_done`). `done` is a one-cycle pulse.
- R12: After reset the block is idle: `req_ready` = 1, and `done`, `bus_go`, `rd_valid` and `wr_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request can be taken |
| req_op | input | 2 | 0 probe, 1 read, 2 write, 3 probe |
| req_chip | input | 7 | 7-bit device address |
| req_addr | input | 8*ADDR_BYTES | Internal address |
| req_alen | input | clog2(ADDR_BYTES+1) | Internal address length in bytes |
| req_len | input | LEN_W | Data byte count |
| wr_data | input | 8 | Outgoing data byte |
| wr_valid | input | 1 | Outgoing byte present |
| wr_ready | output | 1 | Block takes outgoing byte |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte present |
| rd_ready | input | 1 | Consumer takes received byte |
| bus_go | output | 1 | Pulse: engine executes the command |
| bus_cmd | output | 2 | 0 START, 1 STOP, 2 byte write, 3 byte read |
| bus_byte | output | 8 | Byte to send for a write |
| bus_nack | output | 1 | Acknowledge level for a read (1 = NACK) |
| bus_done | input | 1 | Pulse: engine finished the command |
| bus_rx_byte | input | 8 | Byte received by a read |
| bus_rx_nack | input | 1 | Acknowledge level seen after a write (1 = NACK) |
| done | output | 1 | Pulse: transaction complete |
| done_err | output | 1 | Transaction failed |
| done_fails | output | LEN_W | Refused data bytes of a write |

## Verification
The assertions check the handshake rules on every cycle: a taken request makes the block busy, bus commands never overlap, the completion pulse lasts one cycle, a stalled read byte stays put, and the last read carries the NACK level. Command order and its branches can only be shown by the bench's scenarios. These include pointer skipping, mid-transaction STOP/START, abort points with and without STOP, failure counting, address folding and zero-length cases. An engine model logs every command, and the bench compares that log with a sequence built from the requirements.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_STOP  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_READ  = 2'd3
  } bus_cmd_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CHIPW, PH_ADDR, PH_MIDSTOP, PH_RESTART,
    PH_CHIPR, PH_RDBYTE, PH_RDPUSH, PH_WRFETCH, PH_WRBYTE, PH_ENDSTOP
  } phase_e;
endpackage

// File: rtl/i2cseq_fold.sv
// Folds address bits above the used address bytes into the device address.
module i2cseq_fold #(
  parameter int          ADDR_BYTES = 4,
  parameter logic [6:0]  OVF_MASK   = 7'h07,
  localparam int         AW         = 8 * ADDR_BYTES,
  localparam int         ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic [6:0]        chip,
  input  logic [AW-1:0]     addr,
  input  logic [ALEN_W-1:0] alen,
  output logic [6:0]        chip_eff
);
  logic [6:0] upper;
  assign upper    = 7'(addr >> {alen, 3'b000});
  assign chip_eff = chip | (upper & OVF_MASK);
endmodule

// File: rtl/i2cseq_bytesel.sv
// Picks address byte number idx (0 = least significant).
module i2cseq_bytesel #(
  parameter int  ADDR_BYTES = 4,
  localparam int AW         = 8 * ADDR_BYTES,
  localparam int ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic [AW-1:0]     addr,
  input  logic [ALEN_W-1:0] idx,
  output logic [7:0]        sel
);
  assign sel = 8'(addr >> {idx, 3'b000});
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int          ADDR_BYTES = 4,
  parameter int          LEN_W      = 8,
  parameter logic [6:0]  OVF_MASK   = 7'h07,
  localparam int         AW         = 8 * ADDR_BYTES,
  localparam int         ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_chip,
  input  logic [AW-1:0]     req_addr,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              bus_go,
  output logic [1:0]        bus_cmd,
  output logic [7:0]        bus_byte,
  output logic              bus_nack,
  input  logic              bus_done,
  input  logic [7:0]        bus_rx_byte,
  input  logic              bus_rx_nack,
  output logic              done,
  output logic              done_err,
  output logic [LEN_W-1:0]  done_fails
);
  phase_e             st;
  logic               pend;
  logic [1:0]         op_q;
  logic [6:0]         chip_q;
  logic [AW-1:0]      addr_q;
  logic [ALEN_W-1:0]  alen_q, idx_q;
  logic [LEN_W-1:0]   cnt_q, fails_q;
  logic [7:0]         wbyte_q;
  logic               err_q;

  logic [6:0]         chip_eff;
  logic [7:0]         addr_byte;
  bus_cmd_e           cmd_now;
  logic [7:0]         byte_now;
  phase_e             after_addr;

  i2cseq_fold #(.ADDR_BYTES(ADDR_BYTES), .OVF_MASK(OVF_MASK)) u_fold (
    .chip(req_chip), .addr(req_addr), .alen(req_alen), .chip_eff(chip_eff));

  i2cseq_bytesel #(.ADDR_BYTES(ADDR_BYTES)) u_sel (
    .addr(addr_q), .idx(idx_q), .sel(addr_byte));

  assign req_ready = (st == PH_IDLE);
  assign wr_ready  = (st == PH_WRFETCH);
  assign rd_valid  = (st == PH_RDPUSH);

  always_comb begin
    unique case (st)
      PH_START, PH_RESTART:  cmd_now = BUS_START;
      PH_MIDSTOP, PH_ENDSTOP: cmd_now = BUS_STOP;
      PH_RDBYTE:             cmd_now = BUS_READ;
      default:               cmd_now = BUS_WRITE;
    endcase
    unique case (st)
      PH_CHIPW:  byte_now = {chip_q, 1'b0};
      PH_CHIPR:  byte_now = {chip_q, 1'b1};
      PH_ADDR:   byte_now = addr_byte;
      PH_WRBYTE: byte_now = wbyte_q;
      default:   byte_now = 8'h00;
    endcase
    if (cnt_q == '0)            after_addr = PH_ENDSTOP;
    else if (op_q == OP_READ)   after_addr = PH_MIDSTOP;
    else                        after_addr = PH_WRFETCH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      pend       <= 1'b0;
      bus_go     <= 1'b0;
      bus_cmd    <= 2'd0;
      bus_byte   <= 8'h00;
      bus_nack   <= 1'b0;
      done       <= 1'b0;
      done_err   <= 1'b0;
      done_fails <= '0;
      op_q       <= 2'd0;
      chip_q     <= '0;
      addr_q     <= '0;
      alen_q     <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      fails_q    <= '0;
      wbyte_q    <= 8'h00;
      err_q      <= 1'b0;
      rd_data    <= 8'h00;
    end else begin
      bus_go <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        PH_IDLE: if (req_valid) begin
          op_q    <= req_op;
          chip_q  <= chip_eff;
          addr_q  <= req_addr;
          alen_q  <= req_alen;
          idx_q   <= ALEN_W'(req_alen - 1'b1);
          cnt_q   <= req_len;
          fails_q <= '0;
          err_q   <= 1'b0;
          st      <= PH_START;
        end
        PH_RDPUSH: if (rd_ready) begin
          cnt_q <= cnt_q - 1'b1;
          st    <= (cnt_q == LEN_W'(1)) ? PH_ENDSTOP : PH_RDBYTE;
        end
        PH_WRFETCH: if (wr_valid) begin
          wbyte_q <= wr_data;
          st      <= PH_WRBYTE;
        end
        default: begin
          if (!pend) begin
            bus_go   <= 1'b1;
            bus_cmd  <= cmd_now;
            bus_byte <= byte_now;
            bus_nack <= (st == PH_RDBYTE) && (cnt_q == LEN_W'(1));
            pend     <= 1'b1;
          end else if (bus_done) begin
            pend <= 1'b0;
            unique case (st)
              PH_START:
                st <= (op_q == OP_READ && alen_q == '0) ? PH_CHIPR : PH_CHIPW;
              PH_CHIPW:
                if (bus_rx_nack) begin
                  err_q <= 1'b1;
                  st    <= PH_ENDSTOP;
                end else if (op_q != OP_READ && op_q != OP_WRITE) st <= PH_ENDSTOP;
                else if (alen_q != '0) st <= PH_ADDR;
                else st <= after_addr;
              PH_ADDR:
                if (bus_rx_nack) begin
                  done       <= 1'b1;
                  done_err   <= 1'b1;
                  done_fails <= fails_q;
                  st         <= PH_IDLE;
                end else if (idx_q == '0) st <= after_addr;
                else idx_q <= idx_q - 1'b1;
              PH_MIDSTOP: st <= PH_RESTART;
              PH_RESTART: st <= PH_CHIPR;
              PH_CHIPR:   st <= (cnt_q == '0) ? PH_ENDSTOP : PH_RDBYTE;
              PH_RDBYTE: begin
                rd_data <= bus_rx_byte;
                st      <= PH_RDPUSH;
              end
              PH_WRBYTE: begin
                if (bus_rx_nack) fails_q <= fails_q + 1'b1;
                cnt_q <= cnt_q - 1'b1;
                st    <= (cnt_q == LEN_W'(1)) ? PH_ENDSTOP : PH_WRFETCH;
              end
              default: begin
                done       <= 1'b1;
                done_err   <= err_q;
                done_fails <= fails_q;
                st         <= PH_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  // R1: a taken request leaves the block busy on the next cycle
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11: a command pulse is never followed directly by another
  assert_single_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    bus_go |=> !bus_go);

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a stalled read byte stays offered and unchanged
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R7: only the final read of a burst carries the NACK level
  assert_last_nack_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_go && bus_cmd == BUS_READ) |-> (bus_nack == (cnt_q == LEN_W'(1))));
endmodule

// File: tb/i2cseq_ctrl_test.sv
module i2cseq_ctrl_test;
  localparam int NV = 15;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  chip;
    logic [31:0] addr;
    logic [2:0]  alen;
    logic [7:0]  len;
    logic [15:0] nmask;
  } vec_t;

  // op, chip, addr, alen, len, NACK mask by write-command index
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 16'h0000},
    '{2'd0, 7'h51, 32'h0,        3'd0, 8'd0, 16'h0001},
    '{2'd1, 7'h50, 32'h12,       3'd1, 8'd3, 16'h0000},
    '{2'd1, 7'h50, 32'h1234,     3'd2, 8'd1, 16'h0000},
    '{2'd1, 7'h50, 32'h0,        3'd0, 8'd2, 16'h0000},
    '{2'd1, 7'h50, 32'h12,       3'd1, 8'd2, 16'h0001},
    '{2'd1, 7'h50, 32'h1234,     3'd2, 8'd2, 16'h0004},
    '{2'd2, 7'h50, 32'h40,       3'd1, 8'd3, 16'h0014},
    '{2'd2, 7'h50, 32'h0,        3'd0, 8'd2, 16'h0000},
    '{2'd2, 7'h50, 32'h1234,     3'd2, 8'd0, 16'h0000},
    '{2'd1, 7'h50, 32'h12,       3'd1, 8'd0, 16'h0000},
    '{2'd1, 7'h50, 32'h2A5,      3'd1, 8'd1, 16'h0000},
    '{2'd2, 7'h54, 32'h89ABCDEF, 3'd4, 8'd1, 16'h0000},
    '{2'd2, 7'h50, 32'h12,       3'd1, 8'd2, 16'h0001},
    '{2'd1, 7'h50, 32'h12,       3'd1, 8'd2, 16'h0004}
  };
  string tags [NV] = '{"R2", "R2", "R3", "R3", "R4", "R5", "R6", "R8",
                       "R8", "R10", "R10", "R9", "R9", "R5", "R7"};

  localparam logic [10:0] E_START = {2'd0, 1'b0, 8'h00};
  localparam logic [10:0] E_STOP  = {2'd1, 1'b0, 8'h00};

  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic [1:0]  req_op = 0;
  logic [6:0]  req_chip = 0;
  logic [31:0] req_addr = 0;
  logic [2:0]  req_alen = 0;
  logic [7:0]  req_len = 0;
  logic        rd_ready = 1;
  logic        req_ready, wr_ready, rd_valid, bus_go, bus_nack, done, done_err;
  logic [7:0]  wr_data, rd_data, bus_byte, done_fails;
  logic [1:0]  bus_cmd;
  logic        wr_valid = 1;
  logic        bus_done, bus_rx_nack;
  logic [7:0]  bus_rx_byte;

  always #10 clk = ~clk;

  i2cseq_ctrl #(.ADDR_BYTES(4), .LEN_W(8), .OVF_MASK(7'h03)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chip(req_chip), .req_addr(req_addr),
    .req_alen(req_alen), .req_len(req_len), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .bus_go(bus_go),
    .bus_cmd(bus_cmd), .bus_byte(bus_byte), .bus_nack(bus_nack),
    .bus_done(bus_done), .bus_rx_byte(bus_rx_byte),
    .bus_rx_nack(bus_rx_nack), .done(done), .done_err(done_err),
    .done_fails(done_fails));

  // Bus engine model, write-data source and read-data sink
  logic [15:0] cur_mask = 0;
  logic [10:0] blog [64];
  int          bus_n, widx, ridx, dly, wcnt, rcnt;
  logic [7:0]  rlog [64];
  wire         taken = req_valid && req_ready;

  assign wr_data = 8'h50 + 8'(wcnt);

  always @(posedge clk) begin
    if (rst) begin
      bus_n <= 0; widx <= 0; ridx <= 0; dly <= 0; wcnt <= 0; rcnt <= 0;
      bus_done <= 0; bus_rx_nack <= 0; bus_rx_byte <= 0;
    end else begin
      bus_done <= 0;
      if (dly != 0) begin
        dly <= dly - 1;
        if (dly == 1) bus_done <= 1;
      end
      if (taken) begin
        bus_n <= 0; widx <= 0; ridx <= 0; wcnt <= 0; rcnt <= 0;
      end
      if (bus_go) begin
        blog[bus_n[5:0]] <= {bus_cmd, (bus_cmd == 2'd3) ? bus_nack : 1'b0,
                             (bus_cmd == 2'd2) ? bus_byte : 8'h00};
        bus_n <= bus_n + 1;
        dly   <= 2;
        bus_rx_nack <= (bus_cmd == 2'd2) ? cur_mask[widx[3:0]] : 1'b1;
        bus_rx_byte <= 8'hC0 + 8'(ridx);
        if (bus_cmd == 2'd2) widx <= widx + 1;
        if (bus_cmd == 2'd3) ridx <= ridx + 1;
      end
      if (wr_valid && wr_ready) wcnt <= wcnt + 1;
      if (rd_valid && rd_ready) begin
        rlog[rcnt[5:0]] <= rd_data;
        rcnt <= rcnt + 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected command sequence derived from the requirements
  logic [10:0] exp_log [64];
  int          exp_n, exp_rd_n, exp_fail;
  bit          exp_err;

  task automatic push(input logic [10:0] e);
    exp_log[exp_n] = e;
    exp_n++;
  endtask

  task automatic build_exp(input vec_t v);
    logic [6:0] ce;
    int  wi;
    bit  stop_now;
    ce = v.chip | (7'(64'(v.addr) >> (8 * int'(v.alen))) & 7'h03);   // R9 fold
    exp_n = 0; exp_rd_n = 0; exp_fail = 0; exp_err = 0; wi = 0; stop_now = 0;
    push(E_START);
    if (v.op == 2'd0) begin
      push({2'd2, 1'b0, ce, 1'b0});
      exp_err = v.nmask[0];
      push(E_STOP);
    end else begin
      if (v.op == 2'd2 || v.alen != 0) begin
        push({2'd2, 1'b0, ce, 1'b0});
        if (v.nmask[wi]) begin exp_err = 1; push(E_STOP); stop_now = 1; end
        wi++;
        for (int i = int'(v.alen) - 1; i >= 0; i--) begin
          if (!stop_now) begin
            push({2'd2, 1'b0, 8'(v.addr >> (8 * i))});
            if (v.nmask[wi]) begin exp_err = 1; stop_now = 1; end
            wi++;
          end
        end
      end
      if (!stop_now) begin
        if (v.op == 2'd1) begin
          if (v.alen != 0 && v.len == 0) push(E_STOP);
          else begin
            if (v.alen != 0) begin push(E_STOP); push(E_START); end
            push({2'd2, 1'b0, ce, 1'b1});
            wi++;
            for (int k = 0; k < int'(v.len); k++)
              push({2'd3, (k == int'(v.len) - 1), 8'h00});
            push(E_STOP);
            exp_rd_n = int'(v.len);
          end
        end else begin
          for (int k = 0; k < int'(v.len); k++) begin
            push({2'd2, 1'b0, 8'h50 + 8'(k)});
            if (v.nmask[wi]) exp_fail++;
            wi++;
          end
          push(E_STOP);
        end
      end
    end
  endtask

  task automatic start_req(input vec_t v);
    @(negedge clk);
    cur_mask  = v.nmask;
    req_op    = v.op;
    req_chip  = v.chip;
    req_addr  = v.addr;
    req_alen  = v.alen;
    req_len   = v.len;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  bit got_err;
  int got_fail;

  task automatic wait_done(input string tag);
    int t = 0;
    do begin
      if (!done) @(negedge clk);
      t++;
    end while (!done && t < 3000);
    check(done, {tag, " completion (watchdog)"}, done, 1);
    got_err  = done_err;
    got_fail = int'(done_fails);
    if (!done) begin
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
    end
  endtask

  task automatic check_result(input string tag);
    int bad = 0;
    logic [10:0] a = 0, e = 0;
    check(bus_n == exp_n, {tag, " command count"}, bus_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      if (blog[i] !== exp_log[i] && bad++ == 0) begin a = blog[i]; e = exp_log[i]; end
    check(bad == 0, {tag, " command sequence"}, a, e);
    check(got_err == exp_err, {tag, " error flag"}, got_err, exp_err);
    check(got_fail == exp_fail, {tag, " fail count"}, got_fail, exp_fail);
    check(rcnt == exp_rd_n, {tag, " read byte count"}, rcnt, exp_rd_n);
    for (int i = 0; i < exp_rd_n; i++)
      check(rlog[i] == 8'hC0 + 8'(i), {tag, " read data order"}, rlog[i], 8'hC0 + 8'(i));
  endtask

  initial begin
    vec_t v;
    int   n0;
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: idle after reset
    check(req_ready == 1, "R12 req_ready", req_ready, 1);
    check(done == 0 && bus_go == 0, "R12 done/bus_go", {done, bus_go}, 0);
    check(rd_valid == 0 && wr_ready == 0, "R12 stream flags", {rd_valid, wr_ready}, 0);

    for (int n = 0; n < NV; n++) begin
      build_exp(VECS[n]);
      start_req(VECS[n]);
      wait_done(tags[n]);
      check_result(tags[n]);
    end

    // R1: request while busy is ignored
    v = '{2'd2, 7'h50, 32'h10, 3'd1, 8'd3, 16'h0};
    build_exp(v);
    start_req(v);
    repeat (4) @(negedge clk);
    check(req_ready == 0, "R1 busy flag", req_ready, 0);
    req_op = 2'd0; req_chip = 7'h33; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait_done("R1");
    check_result("R1");
    repeat (10) @(negedge clk);
    check(bus_n == exp_n, "R1 ignored request issued commands", bus_n, exp_n);
    check(req_ready == 1, "R1 idle again", req_ready, 1);

    // R7: read stream backpressure
    v = '{2'd1, 7'h50, 32'h20, 3'd1, 8'd2, 16'h0};
    build_exp(v);
    rd_ready = 0;
    start_req(v);
    for (int t = 0; t < 200 && !rd_valid; t++) @(negedge clk);
    d0 = rd_data;
    n0 = bus_n;
    repeat (6) @(negedge clk);
    check(rd_valid == 1, "R7 byte still offered", rd_valid, 1);
    check(rd_data == d0 && d0 == 8'hC0, "R7 byte held", rd_data, 8'hC0);
    check(bus_n == n0, "R7 no read during stall", bus_n, n0);
    rd_ready = 1;
    wait_done("R7");
    check_result("R7 backpressure");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule